// File: doc/BRIEF.md
# Distributed Daisy-Chain Bus Arbitration Node

This block is the arbitration logic that sits inside one module on a shared bus with no central arbiter. Every module carries a copy. Two bus-wide lines are active-low and open-collector, which makes them a wired-AND: any node can pull them to 0. One line signals that some module wants the bus. The other signals that some module owns it. Priority comes from a chain. Each node passes a permission signal to the next node unless it is requesting itself. The node at the head of the chain has its chain input tied to 1, so it has the highest priority.

A node wins when its local master is requesting and its chain input is 1. After winning, it waits for the busy line to read 1. It then pulls busy low and grants the bus to its local master. The master holds its request level for the whole transfer and drops it when it is done. The node then stops pulling busy, and the line returns to 1. The block only drives pull-down enables (1 means pull the line low). The wired-AND itself is resolved outside the block, and the resolved busy level comes back on an input.

A chain that runs through many modules takes time to ripple. For this reason a win counts only after the chain input has stayed at 1 for a set number of consecutive clock edges while the request is pending. That number is the parameter `SETTLE_CYCLES`.

Top module: `arbn_node`

## Requirements
- R1: In reset and on the first cycle after it, `breq_pull_o`, `busy_pull_o` and `grant_o` are 0, and `chain_o` equals `chain_i`.
- R2: While no request is pending (`breq_pull_o` = 0), `chain_o` follows `chain_i` combinationally.
- R3: From the first edge that samples `req_i` = 1 until the node goes back to idle, `breq_pull_o` is 1 and `chain_o` is 0, whatever `chain_i` is.
- R4: A node that samples `chain_i` = 0 at an edge, and does not own the bus, does not claim the bus at that edge.
- R5: With `req_i`, `chain_i` and `busy_n_i` all held at 1, `grant_o` and `busy_pull_o` rise `SETTLE_CYCLES`+1 edges after the edge at which the request became pending.
- R6: The settle count restarts at zero whenever a pending node samples `chain_i` = 0.
- R7: A winning node does not claim while `busy_n_i` = 0. It claims at the first edge that samples `busy_n_i` = 1.
- R8: `grant_o` is 1 only while the node itself pulls busy low, so the resolved `busy_n_i` is 0 whenever `grant_o` is 1.
- R9: Once it owns the bus, the node keeps `busy_pull_o` and `grant_o` at 1 for as long as `req_i` stays 1, even if `chain_i` falls.
- R10: The edge that samples `req_i` = 0 during ownership clears `grant_o`, `busy_pull_o` and `breq_pull_o`, and `chain_o` follows `chain_i` again.
- R11: A pending node whose `req_i` drops before it claims returns to idle at that edge and never claims.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Local master request; held high for the whole transfer |
| chain_i | input | 1 | Priority chain input; 1 means no upstream node is requesting |
| chain_o | output | 1 | Priority chain output to the next node downstream |
| busy_n_i | input | 1 | Resolved level of the shared active-low busy line |
| breq_pull_o | output | 1 | 1 pulls the shared active-low bus-request line low |
| busy_pull_o | output | 1 | 1 pulls the shared active-low busy line low |
| grant_o | output | 1 | Bus granted to the local master |

## Verification
The bench builds the node with `SETTLE_CYCLES` = 2. With this value a chain input that drops after one edge can be told apart from a steady one: a counter that failed to restart would claim one edge early. It also gives a short window in which to withdraw a request before the claim. The bench plays the rest of the bus itself. It drives the chain input as an upstream node would, and it holds the busy line low the way another owner would. It then resolves that line with the node's own pull-down, so that waiting on busy, holding the bus while the chain falls, and giving the bus up are all seen at the ports.

// File: rtl/arbn_pkg.sv
package arbn_pkg;

  // Node states: idle, request pending (may be waiting for a win or for busy), owner
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_OWN  = 2'd2
  } arbn_state_e;

endpackage

// File: rtl/arbn_settle.sv
// Qualifies the chain input: a win needs chain_i high for SETTLE_CYCLES
// consecutive edges while a request is pending.
module arbn_settle #(
  parameter int SETTLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic chain_i,
  output logic won
);

  generate
    if (SETTLE_CYCLES == 0) begin : g_direct
      assign won = chain_i;
    end else begin : g_count
      localparam int CW = $clog2(SETTLE_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || !pending || !chain_i) begin
          cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign won = chain_i && (cnt_q == LIMIT);
    end
  endgenerate

endmodule

// File: rtl/arbn_fsm.sv
// Ownership state machine with registered line-drive and grant outputs.
module arbn_fsm
  import arbn_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_i,
  input  logic        won,
  input  logic        busy_n_i,
  output arbn_state_e state,
  output logic        breq_pull,
  output logic        busy_pull,
  output logic        grant
);

  arbn_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_PEND;
      ST_PEND: begin
        if (!req_i)                state_d = ST_IDLE;
        else if (won && busy_n_i)  state_d = ST_OWN;
      end
      ST_OWN:  if (!req_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      breq_pull <= 1'b0;
      busy_pull <= 1'b0;
      grant     <= 1'b0;
    end else begin
      state_q   <= state_d;
      breq_pull <= (state_d != ST_IDLE);
      busy_pull <= (state_d == ST_OWN);
      grant     <= (state_d == ST_OWN);
    end
  end

  assign state = state_q;

endmodule

// File: rtl/arbn_node.sv
// One arbitration node of a distributed daisy-chain scheme.
module arbn_node
  import arbn_pkg::*;
#(
  parameter int SETTLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic chain_i,
  output logic chain_o,
  input  logic busy_n_i,
  output logic breq_pull_o,
  output logic busy_pull_o,
  output logic grant_o
);

  arbn_state_e state;
  logic        won;
  logic        breq_pull, busy_pull, grant;

  arbn_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .pending (state == ST_PEND),
    .chain_i (chain_i),
    .won     (won)
  );

  arbn_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .won       (won),
    .busy_n_i  (busy_n_i),
    .state     (state),
    .breq_pull (breq_pull),
    .busy_pull (busy_pull),
    .grant     (grant)
  );

  // A pending or owning node blocks everything downstream
  assign chain_o     = chain_i & ~breq_pull;
  assign breq_pull_o = breq_pull;
  assign busy_pull_o = busy_pull;
  assign grant_o     = grant;

endmodule

// File: rtl/arbn_node_chk.sv
module arbn_node_chk (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic chain_i,
  input logic chain_o,
  input logic busy_n_i,
  input logic breq_pull_o,
  input logic busy_pull_o,
  input logic grant_o
);

  a_r2_idle_pass: assert property (@(posedge clk) disable iff (rst)
    !breq_pull_o |-> (chain_o == chain_i));

  a_r3_chain_blocked: assert property (@(posedge clk) disable iff (rst)
    breq_pull_o |-> !chain_o);

  a_r4_no_claim_blocked: assert property (@(posedge clk) disable iff (rst)
    (!chain_i && !busy_pull_o) |=> !busy_pull_o);

  a_r7_claim_needs_free: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_pull_o) |-> ($past(busy_n_i) && $past(chain_i) && $past(req_i)));

  a_r8_grant_holds_busy: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> !busy_n_i);

  a_r9_keep_ownership: assert property (@(posedge clk) disable iff (rst)
    (busy_pull_o && req_i) |=> busy_pull_o);

  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (busy_pull_o && !req_i) |=> (!busy_pull_o && !breq_pull_o && !grant_o));

endmodule

bind arbn_node arbn_node_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .chain_i     (chain_i),
  .chain_o     (chain_o),
  .busy_n_i    (busy_n_i),
  .breq_pull_o (breq_pull_o),
  .busy_pull_o (busy_pull_o),
  .grant_o     (grant_o)
);

// File: tb/sim_arbn_node.sv
`timescale 1ns/1ps
module sim_arbn_node;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0;
  logic chain_i = 1'b1;
  logic other_busy_n = 1'b1;
  logic chain_o, busy_n_i, breq_pull_o, busy_pull_o, grant_o;
  int   n_chk = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Wired-AND of the busy line: another owner or this node can pull it low
  assign busy_n_i = other_busy_n & ~busy_pull_o;

  arbn_node #(.SETTLE_CYCLES(2)) u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .chain_i(chain_i), .chain_o(chain_o),
    .busy_n_i(busy_n_i), .breq_pull_o(breq_pull_o), .busy_pull_o(busy_pull_o),
    .grant_o(grant_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    req_i = 1'b0;
    tick();
    chk("R10 grant cleared", grant_o, 1'b0);
    chk("R10 busy pull cleared", busy_pull_o, 1'b0);
    chk("R10 request pull cleared", breq_pull_o, 1'b0);
    #1 chk("R10 chain follows", chain_o, chain_i);
  endtask

  task automatic t_reset();
    rst = 1'b1; chain_i = 1'b1; req_i = 1'b0; other_busy_n = 1'b1;
    tick(3);
    chk("R1 reset breq", breq_pull_o, 1'b0);
    chk("R1 reset busy", busy_pull_o, 1'b0);
    chk("R1 reset grant", grant_o, 1'b0);
    rst = 1'b0;
    tick();
    chk("R1 chain after reset", chain_o, 1'b1);
    chain_i = 1'b0; #1;
    chk("R2 idle pass low", chain_o, 1'b0);
    chain_i = 1'b1; #1;
    chk("R2 idle pass high", chain_o, 1'b1);
  endtask

  task automatic t_claim();
    chain_i = 1'b1; req_i = 1'b1;
    tick();
    chk("R3 request pulled", breq_pull_o, 1'b1);
    chk("R3 chain blocked", chain_o, 1'b0);
    tick();
    chk("R5 no grant after 1", grant_o, 1'b0);
    tick();
    chk("R5 no grant after 2", grant_o, 1'b0);
    tick();
    chk("R5 grant after 3", grant_o, 1'b1);
    chk("R5 busy pulled", busy_pull_o, 1'b1);
    chk("R8 busy line low", busy_n_i, 1'b0);
    chk("R3 chain blocked while owner", chain_o, 1'b0);
    release_bus();
  endtask

  task automatic t_blocked_and_hold();
    chain_i = 1'b0; req_i = 1'b1;
    tick(6);
    chk("R4 no grant while blocked", grant_o, 1'b0);
    chk("R3 request pulled while blocked", breq_pull_o, 1'b1);
    chain_i = 1'b1; tick();
    chain_i = 1'b0; tick();
    chain_i = 1'b1; tick();
    chk("R6 restarted count 1", grant_o, 1'b0);
    tick();
    chk("R6 restarted count 2", grant_o, 1'b0);
    tick();
    chk("R6 grant after full settle", grant_o, 1'b1);
    chain_i = 1'b0;
    tick(3);
    chk("R9 hold grant", grant_o, 1'b1);
    chk("R9 hold busy", busy_pull_o, 1'b1);
    release_bus();
  endtask

  task automatic t_busy_wait();
    other_busy_n = 1'b0; chain_i = 1'b1; req_i = 1'b1;
    tick(6);
    chk("R7 wait while busy", grant_o, 1'b0);
    chk("R7 still requesting", breq_pull_o, 1'b1);
    other_busy_n = 1'b1;
    tick();
    chk("R7 claim once free", grant_o, 1'b1);
    release_bus();
  endtask

  task automatic t_withdraw();
    chain_i = 1'b1; req_i = 1'b1;
    tick(2);
    req_i = 1'b0;
    tick();
    chk("R11 request released", breq_pull_o, 1'b0);
    tick(3);
    chk("R11 never claimed", grant_o, 1'b0);
    chk("R11 never pulled busy", busy_pull_o, 1'b0);
  endtask

  initial begin
    tick();
    t_reset();
    t_claim();
    t_blocked_and_hold();
    t_busy_wait();
    t_withdraw();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule